// File: doc/BRIEF.md
# Seven-to-one display link serializer

This block turns a 28-bit parallel pixel word into four serial data lanes plus a fifth lane that carries a framed clock pattern. It runs entirely on a fast bit clock at seven times the pixel rate. The pixel clock arrives as an ordinary input. It is synchronized into the bit-clock domain, and the block captures the pixel word on whichever pixel-clock edge the edge-select input picks.

A one-cycle alignment strobe, high once every seven bit cycles, marks the start of each serial frame. On each strobe the most recently captured word moves atomically into the lane shift registers. Each lane then sends its 7-bit slice, least significant bit first. Alongside the data, the clock lane sends a fixed pattern that repeats at the pixel rate.

An active-low shutdown input clears every register at once and holds all outputs low. After shutdown is released, the lanes stay quiet and the lane enable stays low until a fresh word has been captured and loaded.

Top module: `pix_serializer7`

## Requirements
- R1: While `shdn_n` is low, `lane_d`, `clk_lane` and `lane_en` are all 0, whatever the other inputs do.
- R2: After a word is loaded at a strobe edge, lane k sends `pix_d[7k]` through `pix_d[7k+6]`, one bit per bit cycle, lowest bit first. Bit 0 appears in the cycle after that edge, and all four lanes start on the same cycle.
- R3: While enabled, `clk_lane` sends 1,1,0,0,0,1,1 in the seven bit slots of every frame, in step with data bits 0 to 6.
- R4: The block passes `pclk` through a two-stage synchronizer and samples `pix_d` on the third bit-clock edge after the selected transition reaches the input. The selected transition is the rising edge when `edge_sel` is 1 and the falling edge when it is 0. Transitions of the other polarity capture nothing.
- R5: `lane_en` and all lanes stay 0 until the first strobe edge at which a captured word exists. `lane_en` rises at that edge and stays high until shutdown.
- R6: A strobe with no new capture since the previous load resends the most recently captured word. A word on `pix_d` that no selected edge samples is never sent.
- R7: Driving `shdn_n` low clears all state at once, without waiting for a clock edge. After release, no earlier word is sent and `lane_en` stays low until a new capture has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock, seven times the pixel rate |
| shdn_n | input | 1 | Active-low shutdown and asynchronous clear |
| frame_stb | input | 1 | Frame alignment strobe, one bit cycle in seven |
| pclk | input | 1 | Pixel clock, sampled in the bit-clock domain |
| edge_sel | input | 1 | 1: capture on rising pixel edge, 0: on falling |
| pix_d | input | 28 | Parallel pixel word |
| lane_d | output | 4 | Serial data lanes |
| clk_lane | output | 1 | Framed clock lane |
| lane_en | output | 1 | High once valid frames are being sent |

## Verification
The hardest situation to reach is telling the two capture polarities apart. Both modes produce the same serial stream, one pixel period apart. So the bench drives the pixel word halfway between the edges and checks each frame against the word index that the selected edge implies. If the wrong polarity were used, every frame would be off by one word. The bench also stops the pixel clock while changing `pix_d`, which shows that strobes resend the held word. It cuts shutdown in the middle of an enabled frame, then restarts with new words to show that the old capture is gone.

// File: rtl/pix_serializer7.sv
module pix_serializer7 #(
  parameter int LANES = 4,
  parameter int SLICE = 7,
  parameter int SYNC  = 2,
  parameter logic [SLICE-1:0] PATTERN = 7'b1100011
) (
  input  logic                   bclk,
  input  logic                   shdn_n,
  input  logic                   frame_stb,
  input  logic                   pclk,
  input  logic                   edge_sel,
  input  logic [LANES*SLICE-1:0] pix_d,
  output logic [LANES-1:0]       lane_d,
  output logic                   clk_lane,
  output logic                   lane_en
);
  localparam int WORD = LANES * SLICE;

  logic [SYNC:0]     psync;
  logic [WORD-1:0]   cap_q;
  logic              have_q;
  logic [SLICE-1:0]  ck_sh;

  always_ff @(posedge bclk or negedge shdn_n)
    if (!shdn_n) psync <= '0;
    else         psync <= {psync[SYNC-1:0], pclk};

  wire p_now = psync[SYNC-1];
  wire p_old = psync[SYNC];
  wire take  = edge_sel ? (p_now & ~p_old) : (~p_now & p_old);
  wire load  = frame_stb & have_q;

  always_ff @(posedge bclk or negedge shdn_n)
    if (!shdn_n) begin
      cap_q  <= '0;
      have_q <= 1'b0;
    end else if (take) begin
      cap_q  <= pix_d;
      have_q <= 1'b1;
    end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SLICE-1:0] sh;
    always_ff @(posedge bclk or negedge shdn_n)
      if (!shdn_n)   sh <= '0;
      else if (load) sh <= cap_q[k*SLICE +: SLICE];
      else           sh <= sh >> 1;
    assign lane_d[k] = sh[0];
  end

  always_ff @(posedge bclk or negedge shdn_n)
    if (!shdn_n)   ck_sh <= '0;
    else if (load) ck_sh <= PATTERN;
    else           ck_sh <= ck_sh >> 1;

  assign clk_lane = ck_sh[0];

  always_ff @(posedge bclk or negedge shdn_n)
    if (!shdn_n)   lane_en <= 1'b0;
    else if (load) lane_en <= 1'b1;
endmodule

// File: rtl/pix_serializer7_chk.sv
module pix_serializer7_chk #(
  parameter int LANES = 4
) (
  input logic             bclk,
  input logic             shdn_n,
  input logic             frame_stb,
  input logic [LANES-1:0] lane_d,
  input logic             clk_lane,
  input logic             lane_en
);
  always @(posedge bclk)
    if (!shdn_n)
      AST_QUIET_IN_SHDN: assert (lane_d == '0 && !clk_lane && !lane_en); // R1

  AST_DARK_UNTIL_EN: assert property (@(posedge bclk) disable iff (!shdn_n)
    !lane_en |-> (lane_d == '0 && !clk_lane)); // R5

  AST_EN_HOLDS: assert property (@(posedge bclk) disable iff (!shdn_n)
    lane_en |=> lane_en); // R5

  AST_EN_ON_STROBE: assert property (@(posedge bclk) disable iff (!shdn_n)
    $rose(lane_en) |-> $past(frame_stb)); // R5

  AST_CLK_LEAD_HIGH: assert property (@(posedge bclk) disable iff (!shdn_n)
    ($past(frame_stb) && lane_en) |-> clk_lane); // R3

  AST_CLK_MID_LOW: assert property (@(posedge bclk) disable iff (!shdn_n)
    ($past(frame_stb, 3) && !$past(frame_stb, 2) && !$past(frame_stb) && lane_en) |-> !clk_lane); // R3

  AST_NO_STALE_AFTER_WAKE: assert property (@(posedge bclk) disable iff (!shdn_n)
    $rose(shdn_n) |-> !lane_en); // R7
endmodule

bind pix_serializer7 pix_serializer7_chk #(.LANES(LANES)) u_chk (
  .bclk(bclk), .shdn_n(shdn_n), .frame_stb(frame_stb),
  .lane_d(lane_d), .clk_lane(clk_lane), .lane_en(lane_en)
);

// File: tb/sim_pix_serializer7.sv
`timescale 1ns/1ps
module sim_pix_serializer7;
  logic        bclk = 0, shdn_n = 0, frame_stb = 0, pclk = 0, edge_sel = 1;
  logic [27:0] pix_d = '0;
  wire  [3:0]  lane_d;
  wire         clk_lane, lane_en;
  int total = 0, bad = 0;
  bit done = 0;
  logic [27:0] wq [0:31];

  localparam logic [27:0] TBL [12] = '{
    28'h0000001, 28'hFFFFFFF, 28'h0000000, 28'hAAAAAAA,
    28'h5555555, 28'h8000000, 28'h7F00000, 28'h00FE000,
    28'h0001FC0, 28'h000007F, 28'h1234567, 28'hC3A5E69
  };
  localparam logic [6:0] CKPAT = 7'b1100011;

  pix_serializer7 u0 (.bclk(bclk), .shdn_n(shdn_n), .frame_stb(frame_stb), .pclk(pclk),
    .edge_sel(edge_sel), .pix_d(pix_d), .lane_d(lane_d), .clk_lane(clk_lane), .lane_en(lane_en));

  always #2.5 bclk = ~bclk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input bit fall, input int nw, input int stop_c);
    logic [27:0] got;
    logic [6:0]  ck;
    int last, act_end;
    edge_sel = !fall; shdn_n = 0; frame_stb = 0; pclk = 0; pix_d = '0;
    for (int i = 0; i < 14; i++) begin
      @(negedge bclk);
      chk("R1 quiet in shutdown", {26'd0, lane_d, clk_lane, lane_en}, 32'd0);
      frame_stb = (i % 7 == 0); pclk = (i % 7 < 4); pix_d = ~pix_d;
    end
    last = 7 * (nw + 5);
    act_end = fall ? nw - 1 : nw;
    got = '0; ck = '0;
    for (int c = 0; c <= last; c++) begin
      @(negedge bclk);
      if (stop_c != 0 && c == stop_c) begin
        shdn_n = 0; #1;
        chk("R7 clear on shutdown", {26'd0, lane_d, clk_lane, lane_en}, 32'd0);
        break;
      end
      if (c >= 1) begin
        int j, L, idx, raw;
        j = (c - 1) % 7; L = (c - 1) / 7;
        for (int k = 0; k < 4; k++) got[7*k + j] = lane_d[k];
        ck[j] = clk_lane;
        if (c == 14) chk("R5 enable low before load", {31'd0, lane_en}, 32'd0);
        if (c == 15) chk("R5 enable at first load", {31'd0, lane_en}, 32'd1);
        if (j == 6) begin
          if (L < 2) begin
            chk("R5 R7 lanes quiet", {4'd0, got}, 32'd0);
            chk("R5 clock lane quiet", {25'd0, ck}, 32'd0);
            chk("R5 enable low", {31'd0, lane_en}, 32'd0);
          end else begin
            raw = fall ? L - 1 : L - 2;
            idx = (raw > nw - 1) ? nw - 1 : raw;
            if (raw > nw - 1) chk("R6 repeat held word", {4'd0, got}, {4'd0, wq[idx]});
            else if (fall)    chk("R4 falling capture R2 lanes", {4'd0, got}, {4'd0, wq[idx]});
            else              chk("R4 rising capture R2 lanes", {4'd0, got}, {4'd0, wq[idx]});
            chk("R3 clock lane pattern", {25'd0, ck}, {25'd0, CKPAT});
            chk("R5 enable high", {31'd0, lane_en}, 32'd1);
          end
        end
      end
      shdn_n = 1;
      frame_stb = (c % 7 == 0);
      pclk = ((c / 7) >= 1 && (c / 7) <= act_end && (c % 7) < 4);
      if (c % 7 == 3) pix_d = ((c / 7) < nw) ? wq[c / 7] : ~wq[nw - 1];
    end
  endtask

  initial begin
    foreach (TBL[i]) wq[i] = TBL[i];
    run(0, 12, 0);
    for (int i = 0; i < 8; i++) wq[i] = 28'h1234567 * (i + 3) ^ {i[3:0], 24'h0};
    run(1, 8, 0);
    for (int i = 0; i < 6; i++) wq[i] = 28'hFEDCBA9 - 28'h0111111 * i;
    run(0, 6, 7 * 4 + 3);
    for (int i = 0; i < 3; i++) wq[i] = 28'h0F0F0F0 + i;
    run(0, 3, 0);
    run(1, 3, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule